// File: doc/BRIEF.md
# Bidirectional Pin Bank with Pull-up Control

This block controls one group of general-purpose pins through three software-visible registers on a small register bus. One register sets which pins are outputs. A second register holds the output levels. A third register returns the synchronized pad levels. For every pin the block drives three pad controls: an output enable, an output value and a pull-up enable.

The output-level register has two roles. On a pin set as an output, its bit is the level that the pin drives. On a pin set as an input, its bit turns the internal pull-up on (1) or leaves the pin floating (0).

Pad levels pass through a two-flop synchronizer before software can read them. The pin count is a parameter, so the same block serves a full 8-pin group or a narrower 5-pin group.

Top module: `pin_bank`

## Requirements
- R1: While reset is held, and after it is released with no bus writes, the direction and level registers read back 0. Every pin then has pad_oe=0, pad_out=0 and pad_pu=0, which makes it a floating input.
- R2: The direction register is at bus address 0. A write there loads bus_wdata, and a read there returns the stored value. A 1 in a bit sets pad_oe for that pin, and a 0 clears it.
- R3: pad_out for a pin equals its level-register bit when the pin's direction bit is 1, and is 0 when the direction bit is 0.
- R4: pad_pu for a pin is 1 exactly when its direction bit is 0 and its level bit is 1. pad_pu and pad_oe are never both 1 on the same pin.
- R5: The level register is at bus address 1. A write there loads bus_wdata, and a read returns the stored value whatever the direction bits are.
- R6: A read at bus address 2 returns pad_in as it was sampled two rising clock edges earlier. A pad change shows up after the second edge and not after the first. Reading this address changes nothing.
- R7: Writes to address 2 or address 3 leave both registers unchanged, and a read at address 3 returns 0.
- R8: A register write takes effect at the first rising clock edge that samples bus_we=1, and the pad outputs follow in the same cycle.
- R9: With the pin count set to 5, every rule above applies to the 5 pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register select: 0 direction, 1 level, 2 pin sample, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | WIDTH | Read data for bus_addr, combinational |
| pad_in | input | WIDTH | Raw pad levels, asynchronous |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin driven level |
| pad_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
The bench steps through pairs of direction and level values: all inputs with pull-ups, all outputs, and mixed patterns. Each pair catches a design that ties the pull-up to the level bit alone, or that lets pad_out leak onto input pins. The bench reads the pin sample one edge and then two edges after a pad change, so a synchronizer with one flop too few or too many is caught. Writes to the sample address and to the unused address are each followed by a readback of both registers, which catches address decoding that corrupts a register. A 5-pin instance runs a mixed pattern of its own to catch width mistakes.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int unsigned ADDR_W      = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_LVL  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_bank_rst_sync.sv
module pin_bank_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lvl_q
);
  logic             dir_en;
  logic             lvl_en;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] lvl_d;

  always_comb begin
    dir_en = wr_en && (sel == SEL_DIR);
    lvl_en = wr_en && (sel == SEL_LVL);
    dir_d  = dir_en ? wdata : dir_q;
    lvl_d  = lvl_en ? wdata : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
    end
  end

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DIR) |=> dir_q == $past(wdata));
  a_r5_lvl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_LVL) |=> lvl_q == $past(wdata));
  a_r7_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_DIR) |=> $stable(dir_q));
  a_r7_lvl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_LVL) |=> $stable(lvl_q));
endmodule

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pin_bank_pad_ctl.sv
module pin_bank_pad_ctl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] drive,
  output logic [WIDTH-1:0] pull
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    always_comb begin
      oe[p]    = dir[p];
      drive[p] = dir[p] & lvl[p];
      pull[p]  = ~dir[p] & lvl[p];
    end
  end

  a_r4_pull_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (pull & oe) == '0);
  a_r3_quiet_input: assert property (@(posedge clk) disable iff (!rst_n)
    (drive & ~oe) == '0);
endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pin_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu
);
  logic             rst_s_n;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lvl_q;
  logic [WIDTH-1:0] pin_s;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(bus_addr);

  pin_bank_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_s_n)
  );

  pin_bank_regs #(.WIDTH(WIDTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_s_n),
    .wr_en (bus_we),
    .sel   (sel),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .lvl_q (lvl_q)
  );

  pin_bank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .async_in (pad_in),
    .sync_out (pin_s)
  );

  pin_bank_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .clk   (clk),
    .rst_n (rst_s_n),
    .dir   (dir_q),
    .lvl   (lvl_q),
    .oe    (pad_oe),
    .drive (pad_out),
    .pull  (pad_pu)
  );

  always_comb begin
    unique case (sel)
      SEL_DIR: bus_rdata = dir_q;
      SEL_LVL: bus_rdata = lvl_q;
      SEL_PIN: bus_rdata = pin_s;
      default: bus_rdata = '0;
    endcase
  end

  // Cycles since reset release, saturating, gates the latency check.
  logic [1:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
  end

  a_r6_pin_latency: assert property (@(posedge clk) disable iff (!rst_s_n)
    (since_rst_q == 2'd2 && sel == SEL_PIN) |-> bus_rdata == $past(pad_in, 2));
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel == SEL_NONE) |-> bus_rdata == '0);
endmodule

// File: tb/pin_bank_tb.sv
module pin_bank_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  W  = 8;
  localparam int  W5 = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   addr;
  logic [W-1:0] wdata;
  logic         we;
  logic [W-1:0] rdata, pin, oe, pout, pu;

  logic [1:0]    addr5;
  logic [W5-1:0] wdata5, rdata5, pin5, oe5, pout5, pu5;
  logic          we5;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .pad_in(pin),
    .pad_oe(oe), .pad_out(pout), .pad_pu(pu)
  );

  pin_bank #(.WIDTH(W5)) dut5_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr5), .bus_wdata(wdata5),
    .bus_we(we5), .bus_rdata(rdata5), .pad_in(pin5),
    .pad_oe(oe5), .pad_out(pout5), .pad_pu(pu5)
  );

  // {direction, level}
  localparam logic [15:0] VEC [6] = '{
    16'h00_FF, 16'hFF_00, 16'hFF_A5, 16'h0F_3C, 16'hA5_5A, 16'h00_00
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    logic [W-1:0] r;
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0; pin = '0;
    addr5 = '0; wdata5 = '0; we5 = 1'b0; pin5 = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 oe in reset", oe, '0);
    chk("R1 pu in reset", pu, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, r); chk("R1 dir after reset", r, '0);
    rd(2'd1, r); chk("R1 lvl after reset", r, '0);
    chk("R1 pad_out after reset", pout, '0);
    chk("R1 pu after reset", pu, '0);

    // Table walk: R2 R3 R4 R5 R8
    foreach (VEC[i]) begin
      logic [W-1:0] d = VEC[i][15:8];
      logic [W-1:0] l = VEC[i][7:0];
      wr(2'd0, d);
      chk("R2 R8 oe after dir write", oe, d);
      wr(2'd1, l);
      chk("R2 oe", oe, d);
      chk("R3 pad_out", pout, d & l);
      chk("R4 pull-up", pu, ~d & l);
      chk("R4 exclusive", pu & oe, '0);
      rd(2'd0, r); chk("R2 dir readback", r, d);
      rd(2'd1, r); chk("R5 lvl readback", r, l);
    end

    // R6 synchronizer latency
    @(negedge clk); addr = 2'd2; pin = 8'h00;
    repeat (3) @(negedge clk);
    chk("R6 settled zero", rdata, 8'h00);
    pin = 8'hC3;
    @(negedge clk);
    chk("R6 not after one edge", rdata, 8'h00);
    @(negedge clk);
    chk("R6 after two edges", rdata, 8'hC3);
    @(negedge clk);
    chk("R6 read has no side effect", rdata, 8'hC3);

    // R7 writes to sample and unused addresses ignored
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h96);
    wr(2'd2, 8'hFF);
    rd(2'd0, r); chk("R7 dir after addr2 write", r, 8'h5A);
    rd(2'd1, r); chk("R7 lvl after addr2 write", r, 8'h96);
    wr(2'd3, 8'h00);
    rd(2'd0, r); chk("R7 dir after addr3 write", r, 8'h5A);
    rd(2'd1, r); chk("R7 lvl after addr3 write", r, 8'h96);
    rd(2'd3, r); chk("R7 addr3 reads zero", r, '0);
    chk("R7 pad_out unchanged", pout, 8'h5A & 8'h96);

    // R9 five-pin instance
    @(negedge clk); addr5 = 2'd0; wdata5 = 5'b10101; we5 = 1'b1;
    @(negedge clk); addr5 = 2'd1; wdata5 = 5'b11001;
    @(negedge clk); we5 = 1'b0; pin5 = 5'b01110; addr5 = 2'd2;
    chk("R9 oe5", oe5, 5'b10101);
    chk("R9 pad_out5", pout5, 5'b10001);
    chk("R9 pu5", pu5, 5'b01000);
    repeat (2) @(negedge clk);
    chk("R9 pin5 sample", rdata5, 5'b01110);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule